// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block is the programmable feedback divider of a frequency synthesizer loop. It is clocked by the output of an external dual-modulus prescaler. The prescaler divides the oscillator signal by P or by P+1, and this block tells it which one to use on every cycle. One frame of the divider is B prescaler cycles long. During the first A of those cycles the prescaler is told to divide by P+1, and during the remaining B−A cycles it divides by P. The oscillator is therefore divided by N = P·B + A per frame, and the block emits one pulse per frame toward the phase detector.

Software-facing settings are given as plain inputs: the main count B, the swallow count A, and a bit that selects the prescaler pair 64/65 or 128/129. A setting is only adopted at a frame boundary. A setting whose B is below 3 or below the effective A is flagged and is never adopted; the divider keeps running with the last legal setting. Gapless coverage of every N therefore starts at P·(P−1). Below that value, some N cannot be reached because they would need B < A.

The control core is a three-state machine:
- **ST_IDLE** is the state after reset.
- **ST_SWALLOW** drives the prescaler to P+1.
- **ST_MAIN** drives it to P.

Its transitions are:
- IDLE→SWALLOW or IDLE→MAIN at the first prescaler edge. It goes to SWALLOW when the adopted A is nonzero and to MAIN when A is zero.
- SWALLOW→MAIN when the swallow count is used up.
- SWALLOW→SWALLOW or MAIN→MAIN while the frame continues.
- Any state → frame restart (SWALLOW or MAIN, chosen by the new A) on the last cycle of a frame.

Top module: `pulse_swallow_div`

## Requirements
- R1: Each frame spans P·B + A_eff oscillator cycles. P is 64 when `cfg_p128`=0 and 128 when `cfg_p128`=1. A_eff is defined in R4.
- R2: `mod_hi` (1 = divide by P+1, 0 = divide by P) is high for exactly the first A_eff prescaler cycles of a frame and low for the rest. It never rises again before the next frame.
- R3: `div_pulse` is high for exactly one prescaler cycle per frame, in the first cycle of the frame, so pulses are B prescaler cycles apart.
- R4: With `cfg_p128`=0, only `cfg_a[5:0]` is used and bit 6 is ignored. With `cfg_p128`=1, all 7 bits of `cfg_a` form A_eff.
- R5: `cfg_bad` is a combinational flag. It is 1 exactly when `cfg_b` < 3 or `cfg_b` < A_eff.
- R6: A setting presented with `cfg_bad`=1 is not adopted. The previous legal B, A and P stay in force.
- R7: New inputs take effect only at the frame boundary. A change in the middle of a frame leaves that frame's length and `p_sel` unchanged.
- R8: While reset is low, `mod_hi`, `div_pulse` and `p_sel` are 0. If the first setting seen after reset is illegal, the divider runs with B=3, A=0, P=64, giving N=192.
- R9: With A_eff=0, `mod_hi` stays low for the whole frame. With A_eff=B, it stays high for the whole frame.
- R10: `p_sel` drives the prescaler pair select (0 = 64/65, 1 = 128/129). It is the P of the frame in progress and changes only at the first edge of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output, used as clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_b | input | 11 | Requested main count B |
| cfg_a | input | 7 | Requested swallow count A |
| cfg_p128 | input | 1 | Requested prescaler pair, 1 selects 128/129 |
| mod_hi | output | 1 | Modulus control to prescaler, 1 = P+1 |
| p_sel | output | 1 | Prescaler pair select in force |
| div_pulse | output | 1 | One-cycle pulse per frame |
| cfg_bad | output | 1 | Requested setting is illegal |

## Verification
`cfg_bad` is combinational. The bench checks it one nanosecond after it changes the inputs.

`mod_hi`, `div_pulse` and `p_sel` move on prescaler edges. A new setting is adopted at the first frame start after it is applied. The bench therefore always waits for that frame start, and then judges the next complete frame. It samples shortly after each falling edge of the prescaler output.

The bench's behavioural prescaler derives the prescaler clock from the 125 MHz oscillator stand-in. The frame length is counted in oscillator cycles and compared with P·B + A_eff. In the same frame, the bench counts prescaler cycles and high-modulus cycles.

The mid-frame test changes the inputs two prescaler cycles into a frame. It then expects the old length for that frame and the new length for the frame after it.

// File: rtl/pswl_pkg.sv
package pswl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_MAIN    = 2'd2
    } frame_state_t;
endpackage

// File: rtl/pswl_cfg_guard.sv
module pswl_cfg_guard #(
    parameter int B_W   = 11,
    parameter int A_W   = 7,
    parameter int B_MIN = 3,
    parameter int DEF_B = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [B_W-1:0] cfg_b,
    input  logic [A_W-1:0] cfg_a,
    input  logic           cfg_p128,
    output logic           cfg_bad,
    output logic [B_W-1:0] sel_b,
    output logic [A_W-1:0] sel_a,
    output logic           held_p
);
    localparam int A_LO_W = A_W - 1;
    localparam int PAD_W  = B_W - A_W;

    logic [A_W-1:0] a_eff;
    logic [B_W-1:0] a_ext;
    logic [B_W-1:0] held_b;
    logic [A_W-1:0] held_a;

    // Effective swallow count: the top bit only counts in 128/129 mode.
    always_comb begin
        if (cfg_p128) a_eff = cfg_a;
        else          a_eff = {1'b0, cfg_a[A_LO_W-1:0]};
        a_ext   = {{PAD_W{1'b0}}, a_eff};
        cfg_bad = (cfg_b < B_W'(B_MIN)) || (cfg_b < a_ext);
    end

    // An illegal request falls back to the setting in force.
    assign sel_b = cfg_bad ? held_b : cfg_b;
    assign sel_a = cfg_bad ? held_a : a_eff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_b <= B_W'(DEF_B);
            held_a <= '0;
            held_p <= 1'b0;
        end else if (load) begin
            held_b <= sel_b;
            held_a <= sel_a;
            if (!cfg_bad) held_p <= cfg_p128;
        end
    end

    AST_HELD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (held_b >= B_W'(B_MIN)) && (held_b >= {{PAD_W{1'b0}}, held_a})); // R6

    AST_HOLD_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        (load && cfg_bad) |=> ($stable(held_b) && $stable(held_a) && $stable(held_p))); // R6
endmodule

// File: rtl/pswl_down_cnt.sv
module pswl_down_cnt #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         at_one
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt <= '0;
        else if (load)               cnt <= load_val;
        else if (dec && cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign at_one = (cnt == W'(1));
endmodule

// File: rtl/pswl_fsm.sv
module pswl_fsm
    import pswl_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         b_at_one,
    input  logic         a_at_one,
    input  logic         a_load_zero,
    output logic         load,
    output logic         a_dec,
    output logic         b_dec,
    output logic         mod_hi,
    output logic         div_pulse,
    output frame_state_t state
);
    frame_state_t nxt;
    frame_state_t restart;

    assign load    = (state == ST_IDLE) || b_at_one;
    assign restart = a_load_zero ? ST_MAIN : ST_SWALLOW;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    nxt = restart;
            ST_SWALLOW: begin
                if (b_at_one)      nxt = restart;
                else if (a_at_one) nxt = ST_MAIN;
                else               nxt = ST_SWALLOW;
            end
            ST_MAIN:    nxt = b_at_one ? restart : ST_MAIN;
            default:    nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_pulse <= 1'b0;
        else        div_pulse <= load;
    end

    assign mod_hi = (state == ST_SWALLOW);
    assign a_dec  = (state == ST_SWALLOW) && !load;
    assign b_dec  = !load;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse); // R3

    AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MAIN && !load) |=> !mod_hi); // R2

    AST_PULSE_MATCHES_START: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> div_pulse); // R3
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
    import pswl_pkg::*;
#(
    parameter int B_W   = 11,
    parameter int A_W   = 7,
    parameter int B_MIN = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [B_W-1:0] cfg_b,
    input  logic [A_W-1:0] cfg_a,
    input  logic           cfg_p128,
    output logic           mod_hi,
    output logic           p_sel,
    output logic           div_pulse,
    output logic           cfg_bad
);
    localparam int PAD_W = B_W - A_W;

    logic           load, a_dec, b_dec, a_at_one, b_at_one;
    logic [B_W-1:0] sel_b, b_cnt;
    logic [A_W-1:0] sel_a, a_cnt;
    frame_state_t   state;

    pswl_cfg_guard #(.B_W(B_W), .A_W(A_W), .B_MIN(B_MIN), .DEF_B(B_MIN)) u_guard (
        .clk(clk), .rst_n(rst_n), .load(load),
        .cfg_b(cfg_b), .cfg_a(cfg_a), .cfg_p128(cfg_p128),
        .cfg_bad(cfg_bad), .sel_b(sel_b), .sel_a(sel_a), .held_p(p_sel)
    );

    pswl_down_cnt #(.W(B_W)) u_main_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(sel_b),
        .dec(b_dec), .cnt(b_cnt), .at_one(b_at_one)
    );

    pswl_down_cnt #(.W(A_W)) u_swallow_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(sel_a),
        .dec(a_dec), .cnt(a_cnt), .at_one(a_at_one)
    );

    pswl_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .b_at_one(b_at_one), .a_at_one(a_at_one), .a_load_zero(sel_a == '0),
        .load(load), .a_dec(a_dec), .b_dec(b_dec),
        .mod_hi(mod_hi), .div_pulse(div_pulse), .state(state)
    );

    AST_SWALLOW_WITHIN_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> ({{PAD_W{1'b0}}, a_cnt} <= b_cnt)); // R2

    AST_PSEL_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(p_sel)); // R10

    AST_FRAME_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (b_cnt >= B_W'(B_MIN))); // R1
endmodule

// File: tb/pulse_swallow_div_bench.sv
module pulse_swallow_div_bench;
    logic        rf_clk = 1'b0;
    logic        pre_clk = 1'b0;
    logic        rst_n;
    logic [10:0] cfg_b;
    logic [6:0]  cfg_a;
    logic        cfg_p128;
    logic        mod_hi, p_sel, div_pulse, cfg_bad;

    int total = 0;
    int bad = 0;
    int rf_cnt = 0;
    int pc_cnt = 0;
    int pc_len = 64;

    int frames = 0;
    int fr_len = 0, fr_cyc = 0, fr_hi = 0, fr_order = 0;
    int mark = 0, cur_cyc = 0, cur_hi = 0, seen_lo = 0, order_bad = 0;

    always #4 rf_clk = ~rf_clk;

    pulse_swallow_div u_pulse_swallow_div (
        .clk(pre_clk), .rst_n(rst_n), .cfg_b(cfg_b), .cfg_a(cfg_a),
        .cfg_p128(cfg_p128), .mod_hi(mod_hi), .p_sel(p_sel),
        .div_pulse(div_pulse), .cfg_bad(cfg_bad)
    );

    // Behavioural dual-modulus prescaler: each cycle lasts P or P+1 oscillator cycles,
    // the modulus being sampled two oscillator cycles after the cycle starts.
    always @(posedge rf_clk) begin
        rf_cnt <= rf_cnt + 1;
        if (pc_cnt >= pc_len - 1) begin
            pc_cnt  <= 0;
            pre_clk <= 1'b1;
        end else begin
            pc_cnt  <= pc_cnt + 1;
            pre_clk <= (pc_cnt + 1 < 2);
            if (pc_cnt + 1 == 2) pc_len <= (p_sel ? 128 : 64) + (mod_hi ? 1 : 0);
        end
    end

    // Frame monitor, sampled after the prescaler clock falls
    always begin
        @(negedge pre_clk);
        #1;
        if (div_pulse) begin
            fr_len = rf_cnt - mark; fr_cyc = cur_cyc; fr_hi = cur_hi; fr_order = order_bad;
            frames = frames + 1;
            mark = rf_cnt; cur_cyc = 1; cur_hi = mod_hi ? 1 : 0;
            seen_lo = mod_hi ? 0 : 1; order_bad = 0;
        end else begin
            cur_cyc = cur_cyc + 1;
            if (mod_hi) begin
                cur_hi = cur_hi + 1;
                if (seen_lo != 0) order_bad = 1;
            end else seen_lo = 1;
        end
    end

    function automatic int exp_aeff(input int a, input bit p);
        return p ? (a & 127) : (a & 63);
    endfunction

    function automatic int exp_n(input int b, input int a, input bit p);
        return (p ? 128 : 64) * b + exp_aeff(a, p);
    endfunction

    function automatic bit exp_bad(input int b, input int a, input bit p);
        return (b < 3) || (b < exp_aeff(a, p));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_frames(input int n);
        int f0;
        f0 = frames;
        while (frames < f0 + n) @(posedge rf_clk);
        #2;
    endtask

    task automatic drive(input int b, input int a, input bit p);
        @(negedge pre_clk);
        #2;
        cfg_b = 11'(b); cfg_a = 7'(a); cfg_p128 = p;
        #1;
        chk(cfg_bad == exp_bad(b, a, p), "R5 cfg_bad", int'(cfg_bad), int'(exp_bad(b, a, p)));
    endtask

    // Apply a legal setting and check the first complete frame that uses it.
    task automatic measure(input int b, input int a, input bit p, input string tag);
        drive(b, a, p);
        wait_frames(2);
        chk(fr_len == exp_n(b, a, p), {tag, " R1 length"}, fr_len, exp_n(b, a, p));
        chk(fr_cyc == b, {tag, " R3 pulse spacing"}, fr_cyc, b);
        chk(fr_hi == exp_aeff(a, p), {tag, " R2 high cycles"}, fr_hi, exp_aeff(a, p));
        chk(fr_order == 0, {tag, " R2 order"}, fr_order, 0);
        chk(p_sel == p, {tag, " R10 p_sel"}, int'(p_sel), int'(p));
    endtask

    task automatic finish_up;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge rf_clk);
        total = total + 1;
        bad = bad + 1;
        $display("FAIL watchdog actual=%0d expected=%0d", frames, 0);
        finish_up();
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        cfg_b = 11'd0; cfg_a = 7'd0; cfg_p128 = 1'b1;
        repeat (20) @(posedge rf_clk);
        #1;
        chk(mod_hi == 1'b0, "R8 mod_hi in reset", int'(mod_hi), 0);
        chk(div_pulse == 1'b0, "R8 div_pulse in reset", int'(div_pulse), 0);
        chk(p_sel == 1'b0, "R8 p_sel in reset", int'(p_sel), 0);
        chk(cfg_bad == 1'b1, "R5 b=0 flagged", int'(cfg_bad), 1);
        rst_n = 1'b1;

        // Defaults in force when the first request is illegal
        wait_frames(3);
        chk(fr_len == 192, "R8 default length", fr_len, 192);
        chk(p_sel == 1'b0, "R8 default p_sel", int'(p_sel), 0);

        // Directed corners
        measure(3, 0, 1'b0, "min64");             // R9: A=0
        measure(3, 0, 1'b1, "min128");
        measure(5, 5, 1'b0, "a_eq_b");            // R9: A=B
        measure(5, 7'h45, 1'b0, "R4 upper bit ignored");
        measure(70, 70, 1'b1, "R4 seven bit A");
        measure(63, 63, 1'b0, "p64 full swallow");

        // R6: illegal request leaves previous setting
        measure(4, 2, 1'b0, "pre_illegal");
        drive(2, 0, 1'b1);
        wait_frames(2);
        chk(fr_len == exp_n(4, 2, 1'b0), "R6 length kept", fr_len, exp_n(4, 2, 1'b0));
        chk(p_sel == 1'b0, "R6 p_sel kept", int'(p_sel), 0);
        drive(6, 9, 1'b0);
        wait_frames(2);
        chk(fr_len == exp_n(4, 2, 1'b0), "R6 B<A kept", fr_len, exp_n(4, 2, 1'b0));
        chk(fr_hi == 2, "R6 swallow kept", fr_hi, 2);

        // R7: change in the middle of a frame
        drive(8, 3, 1'b0);
        wait_frames(1);
        @(negedge pre_clk);
        @(negedge pre_clk);
        #2;
        cfg_b = 11'd4; cfg_a = 7'd1; cfg_p128 = 1'b1;
        #1;
        chk(p_sel == 1'b0, "R7 p_sel mid frame", int'(p_sel), 0);
        wait_frames(1);
        chk(fr_len == exp_n(8, 3, 1'b0), "R7 old frame length", fr_len, exp_n(8, 3, 1'b0));
        wait_frames(1);
        chk(fr_len == exp_n(4, 1, 1'b1), "R7 new frame length", fr_len, exp_n(4, 1, 1'b1));

        // Constrained random legal settings
        for (int i = 0; i < 10; i++) begin
            int a;
            int b;
            bit p;
            a = int'($urandom_range(0, 7));
            b = ((a < 3) ? 3 : a) + int'($urandom_range(0, 5));
            p = 1'($urandom_range(0, 1));
            measure(b, a, p, "random");
        end

        finish_up();
    end
endmodule